// File: doc/BRIEF.md
# Address Translation Cache with Selective Flush

A fully associative cache of page translations that sits between an address generator and the memory system. Each entry maps a logical page number to a physical page number. Each entry carries a valid bit, a global bit, an owner mode tag (user or supervisor), a supervisor-only bit, a write-protect bit, a used bit and a modified bit. A request names a full logical address, the privilege mode and whether the access writes. It is answered one cycle later with the physical address or a status code.

Two request flavours share the port. A plain lookup that misses answers at once with a miss status and pulses a walk request to an external table-walk agent. A probe that misses holds the walk request and stays open until the agent returns a fill, which loads the entry and completes the probe. Four flush modes invalidate entries by a combination of page, owner mode and the global bit. A disable input, synchronised and then sampled only on access boundaries, turns translation into an identity mapping without touching the stored entries.

Top module: `xlat_cache`

## Requirements
- R1: While the effective bypass state is set, every accepted request (lookup or probe) answers one cycle later with status OK (0) and an address equal to the request address. It raises no walk request and changes no entry.
- R2: The effective bypass state changes only in a cycle with `boundary_i` high, and it takes the value of `bypass_i` after `SYNC_STAGES` synchronising flops. A change of `bypass_i` with no boundary has no effect on translation.
- R3: Flush commands update the entries while bypass is in effect. Entries flushed then are missing after translation resumes.
- R4: Flush mode 0 invalidates every entry. Flush mode 1 invalidates only entries whose global bit is clear.
- R5: Flush mode 2 invalidates the entry whose page equals `flush_vpn_i` and whose owner tag equals `flush_sup_i`. Mode 3 also requires the entry's global bit to be clear.
- R6: A request matches an entry when the pages are equal and the entry is either global or has an owner tag equal to `acc_sup_i`. A hit that passes the checks answers one cycle later with status OK (0) and the address {physical page, page offset}.
- R7: A hit on a supervisor-only entry from user mode answers with status 2. Otherwise a write hit on a write-protected entry answers with status 3. The privilege fault wins when both apply. Every non-OK answer carries address 0.
- R8: A lookup (`acc_probe_i`=0) that misses answers one cycle later with status 1. In that same cycle, `walk_req_o` is high for one cycle with the page, mode and write flag on the walk outputs.
- R9: A probe (`acc_probe_i`=1) that misses gives no answer. It holds `walk_req_o` high until a fill arrives, and further requests in that time are ignored. The fill completes the probe with the permission checks applied to the filled entry. A fill with `fill_err_i` set completes it with status 4 and loads nothing.
- R10: An OK hit sets the entry's used bit, and an OK write hit sets its modified bit. A fill that completes an OK probe sets used, and also modified for a write probe. `rsp_used_o` and `rsp_mod_o` report the bits after the access, and the bits persist.
- R11: Only one command is taken per cycle, in the order flush, then fill, then request. A command that loses gets no response and has no effect.
- R12: Fills go to slots chosen round-robin over `ENTRIES` slots. A fill also invalidates any entry that could match the same request as the new one, so at most one entry ever hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | Translation disable request |
| boundary_i | input | 1 | Access boundary strobe; bypass state updates here |
| acc_valid_i | input | 1 | Request valid |
| acc_probe_i | input | 1 | 1 = probe, 0 = lookup |
| acc_sup_i | input | 1 | 1 = supervisor mode |
| acc_write_i | input | 1 | 1 = write access or write-form probe |
| acc_addr_i | input | ADDR_W | Logical address |
| fill_valid_i | input | 1 | Fill from walk agent |
| fill_err_i | input | 1 | Walk failed (bad descriptor or bus error) |
| fill_vpn_i | input | VPN_W | Logical page of fill |
| fill_ppn_i | input | VPN_W | Physical page of fill |
| fill_glob_i | input | 1 | Global bit of fill |
| fill_tag_sup_i | input | 1 | Owner mode tag of fill |
| fill_sup_only_i | input | 1 | Supervisor-only bit of fill |
| fill_wprot_i | input | 1 | Write-protect bit of fill |
| flush_valid_i | input | 1 | Flush command |
| flush_mode_i | input | 2 | 0 all, 1 nonglobal, 2 page, 3 page nonglobal |
| flush_vpn_i | input | VPN_W | Page for modes 2 and 3 |
| flush_sup_i | input | 1 | Owner mode for modes 2 and 3 |
| rsp_valid_o | output | 1 | Response valid |
| rsp_status_o | output | 3 | 0 OK, 1 miss, 2 privilege, 3 write-protect, 4 walk error |
| rsp_addr_o | output | ADDR_W | Physical address (0 on fault or miss) |
| rsp_used_o | output | 1 | Entry used bit after access |
| rsp_mod_o | output | 1 | Entry modified bit after access |
| walk_req_o | output | 1 | Table walk request |
| walk_vpn_o | output | VPN_W | Page to walk |
| walk_sup_o | output | 1 | Mode of walked access |
| walk_write_o | output | 1 | Write flag of walked access |

## Verification
The bench goes after entries whose match depends on the global bit and on the owner tag. A design that ignores either would hit on the wrong mode or flush an entry that mode 1 or 3 must spare. It toggles the disable input without a boundary and flushes while bypassed. A design that switches at once, or that blocks flushes in bypass, returns translated addresses where identity is due or keeps stale entries afterwards. It also checks that a pending probe ignores new requests and finishes from the fill with the fill's own permissions, that a flush or fill drops a request in the same cycle, and that the seventeenth fill evicts the oldest slot. A design with the wrong priority or victim choice answers requests that should vanish, or keeps the oldest page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_MISS  = 3'd1,
    ST_PRIV  = 3'd2,
    ST_WPROT = 3'd3,
    ST_WALK  = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_ALL_NG  = 2'd1,
    FL_PAGE    = 2'd2,
    FL_PAGE_NG = 2'd3
  } flush_e;

  typedef struct packed {
    logic valid;
    logic glob;
    logic tag_sup;
    logic sup_only;
    logic wprot;
    logic used;
    logic modif;
  } attr_t;

  function automatic status_e perm_chk(logic sup_only, logic wprot, logic sup, logic wr);
    if (sup_only && !sup)  return ST_PRIV;
    else if (wprot && wr)  return ST_WPROT;
    else                   return ST_OK;
  endfunction

endpackage

// File: rtl/xlat_mode_sync.sv
module xlat_mode_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic boundary_i,
  output logic byp_o
);

  logic byp_raw;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign byp_raw = bypass_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s_q <= '0;
        end else begin
          s_q[0] <= bypass_i;
          for (int k = 1; k < SYNC_STAGES; k++) s_q[k] <= s_q[k-1];
        end
      end
      assign byp_raw = s_q[SYNC_STAGES-1];
    end
  endgenerate

  // state only moves on an access boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         byp_o <= 1'b0;
    else if (boundary_i) byp_o <= byp_raw;
  end

endmodule

// File: rtl/xlat_victim_ptr.sv
module xlat_victim_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  generate
    if ((1 << IDX_W) == ENTRIES) begin : g_pow2
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    idx_o <= '0;
        else if (adv_i) idx_o <= idx_o + 1'b1;
      end
    end else begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    idx_o <= '0;
        else if (adv_i) idx_o <= (idx_o == LAST) ? '0 : idx_o + 1'b1;
      end
    end
  endgenerate

  p_ptr_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST);

endmodule

// File: rtl/xlat_tag_store.sv
module xlat_tag_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // lookup
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_sup_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic             hit_sup_only_o,
  output logic             hit_wprot_o,
  output logic             hit_mod_o,
  // history update
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             touch_wr_i,
  // fill
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  attr_t            fill_attr_i,
  // flush
  input  logic             flush_i,
  input  flush_e           flush_mode_i,
  input  logic [VPN_W-1:0] flush_vpn_i,
  input  logic             flush_sup_i
);

  logic [ENTRIES-1:0]            lk_m;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_w;
  attr_t [ENTRIES-1:0]           attr_w;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    attr_t            a_q;
    logic [VPN_W-1:0] v_q;
    logic [PPN_W-1:0] p_q;
    logic             sel_fill, sel_touch, ovl, fl_hit;

    assign sel_fill  = fill_i  && (fill_idx_i  == IDX_W'(i));
    assign sel_touch = touch_i && (touch_idx_i == IDX_W'(i));
    assign lk_m[i]   = a_q.valid && (v_q == lk_vpn_i) && (a_q.glob || a_q.tag_sup == lk_sup_i);
    // entry would answer some request the new fill also answers
    assign ovl       = a_q.valid && (v_q == fill_vpn_i) &&
                       (a_q.glob || fill_attr_i.glob || a_q.tag_sup == fill_attr_i.tag_sup);

    always_comb begin
      unique case (flush_mode_i)
        FL_ALL:     fl_hit = 1'b1;
        FL_ALL_NG:  fl_hit = !a_q.glob;
        FL_PAGE:    fl_hit = (v_q == flush_vpn_i) && (a_q.tag_sup == flush_sup_i);
        FL_PAGE_NG: fl_hit = (v_q == flush_vpn_i) && (a_q.tag_sup == flush_sup_i) && !a_q.glob;
        default:    fl_hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
      end else if (flush_i) begin
        if (fl_hit) a_q.valid <= 1'b0;
      end else if (fill_i) begin
        if (sel_fill) a_q       <= fill_attr_i;
        else if (ovl) a_q.valid <= 1'b0;
      end else if (sel_touch) begin
        a_q.used <= 1'b1;
        if (touch_wr_i) a_q.modif <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel_fill) begin
        v_q <= fill_vpn_i;
        p_q <= fill_ppn_i;
      end
    end

    assign ppn_w[i]  = p_q;
    assign attr_w[i] = a_q;
  end

  always_comb begin
    hit_idx_o = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (lk_m[k]) hit_idx_o = IDX_W'(k);
    end
  end

  assign hit_o          = |lk_m;
  assign hit_ppn_o      = ppn_w[hit_idx_o];
  assign hit_sup_only_o = attr_w[hit_idx_o].sup_only;
  assign hit_wprot_o    = attr_w[hit_idx_o].wprot;
  assign hit_mod_o      = attr_w[hit_idx_o].modif;

  p_single_hit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_m));

  p_touch_on_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |-> hit_o);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_W      = 12,
  parameter int ENTRIES     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int VPN_W      = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              boundary_i,
  input  logic              acc_valid_i,
  input  logic              acc_probe_i,
  input  logic              acc_sup_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              fill_valid_i,
  input  logic              fill_err_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [VPN_W-1:0]  fill_ppn_i,
  input  logic              fill_glob_i,
  input  logic              fill_tag_sup_i,
  input  logic              fill_sup_only_i,
  input  logic              fill_wprot_i,
  input  logic              flush_valid_i,
  input  logic [1:0]        flush_mode_i,
  input  logic [VPN_W-1:0]  flush_vpn_i,
  input  logic              flush_sup_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_status_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_used_o,
  output logic              rsp_mod_o,
  output logic              walk_req_o,
  output logic [VPN_W-1:0]  walk_vpn_o,
  output logic              walk_sup_o,
  output logic              walk_write_o
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              byp_q;
  logic              pend_q, pend_sup_q, pend_wr_q;
  logic [PAGE_W-1:0] pend_off_q;
  logic [VPN_W-1:0]  acc_vpn;
  logic [PAGE_W-1:0] acc_off;
  logic              do_acc, do_fill, miss_ev, cmpl, load_en;
  logic              hit, hit_sup_only, hit_wprot, hit_mod, touch;
  logic [IDX_W-1:0]  hit_idx, victim;
  logic [VPN_W-1:0]  hit_ppn;
  status_e           acc_stat, fill_stat, rsp_stat_d, rsp_stat_q;
  attr_t             fill_attr;
  logic              rsp_valid_d, rsp_used_d, rsp_mod_d;
  logic [ADDR_W-1:0] rsp_addr_d;

  assign acc_vpn = acc_addr_i[ADDR_W-1:PAGE_W];
  assign acc_off = acc_addr_i[PAGE_W-1:0];

  // one command per cycle: flush > fill > request
  assign do_fill = fill_valid_i && !flush_valid_i;
  assign do_acc  = acc_valid_i && !flush_valid_i && !fill_valid_i && !pend_q;
  assign miss_ev = do_acc && !byp_q && !hit;
  assign cmpl    = do_fill && pend_q;
  assign load_en = do_fill && !fill_err_i;

  xlat_mode_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bypass_i   (bypass_i),
    .boundary_i (boundary_i),
    .byp_o      (byp_q)
  );

  xlat_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (load_en),
    .idx_o  (victim)
  );

  always_comb begin
    acc_stat  = perm_chk(hit_sup_only, hit_wprot, acc_sup_i, acc_write_i);
    fill_stat = fill_err_i ? ST_WALK : perm_chk(fill_sup_only_i, fill_wprot_i, pend_sup_q, pend_wr_q);
    fill_attr = '{valid:    1'b1,
                  glob:     fill_glob_i,
                  tag_sup:  fill_tag_sup_i,
                  sup_only: fill_sup_only_i,
                  wprot:    fill_wprot_i,
                  used:     cmpl && fill_stat == ST_OK,
                  modif:    cmpl && fill_stat == ST_OK && pend_wr_q};
  end

  assign touch = do_acc && !byp_q && hit && acc_stat == ST_OK;

  xlat_tag_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lk_vpn_i       (acc_vpn),
    .lk_sup_i       (acc_sup_i),
    .hit_o          (hit),
    .hit_idx_o      (hit_idx),
    .hit_ppn_o      (hit_ppn),
    .hit_sup_only_o (hit_sup_only),
    .hit_wprot_o    (hit_wprot),
    .hit_mod_o      (hit_mod),
    .touch_i        (touch),
    .touch_idx_i    (hit_idx),
    .touch_wr_i     (acc_write_i),
    .fill_i         (load_en),
    .fill_idx_i     (victim),
    .fill_vpn_i     (fill_vpn_i),
    .fill_ppn_i     (fill_ppn_i),
    .fill_attr_i    (fill_attr),
    .flush_i        (flush_valid_i),
    .flush_mode_i   (flush_e'(flush_mode_i)),
    .flush_vpn_i    (flush_vpn_i),
    .flush_sup_i    (flush_sup_i)
  );

  always_comb begin
    rsp_valid_d = 1'b0;
    rsp_stat_d  = ST_OK;
    rsp_addr_d  = '0;
    rsp_used_d  = 1'b0;
    rsp_mod_d   = 1'b0;
    if (cmpl) begin
      rsp_valid_d = 1'b1;
      rsp_stat_d  = fill_stat;
      if (fill_stat == ST_OK) begin
        rsp_addr_d = {fill_ppn_i, pend_off_q};
        rsp_used_d = 1'b1;
        rsp_mod_d  = pend_wr_q;
      end
    end else if (do_acc) begin
      if (byp_q) begin
        rsp_valid_d = 1'b1;
        rsp_addr_d  = acc_addr_i;
      end else if (hit) begin
        rsp_valid_d = 1'b1;
        rsp_stat_d  = acc_stat;
        if (acc_stat == ST_OK) begin
          rsp_addr_d = {hit_ppn, acc_off};
          rsp_used_d = 1'b1;
          rsp_mod_d  = hit_mod || acc_write_i;
        end
      end else if (!acc_probe_i) begin
        rsp_valid_d = 1'b1;
        rsp_stat_d  = ST_MISS;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_stat_q  <= ST_OK;
      rsp_addr_o  <= '0;
      rsp_used_o  <= 1'b0;
      rsp_mod_o   <= 1'b0;
    end else begin
      rsp_valid_o <= rsp_valid_d;
      rsp_stat_q  <= rsp_stat_d;
      rsp_addr_o  <= rsp_addr_d;
      rsp_used_o  <= rsp_used_d;
      rsp_mod_o   <= rsp_mod_d;
    end
  end

  assign rsp_status_o = rsp_stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_sup_q   <= 1'b0;
      pend_wr_q    <= 1'b0;
      pend_off_q   <= '0;
      walk_req_o   <= 1'b0;
      walk_vpn_o   <= '0;
      walk_sup_o   <= 1'b0;
      walk_write_o <= 1'b0;
    end else begin
      walk_req_o <= miss_ev || (pend_q && !do_fill);
      if (miss_ev) begin
        walk_vpn_o   <= acc_vpn;
        walk_sup_o   <= acc_sup_i;
        walk_write_o <= acc_write_i;
      end
      if (miss_ev && acc_probe_i) begin
        pend_q     <= 1'b1;
        pend_sup_q <= acc_sup_i;
        pend_wr_q  <= acc_write_i;
        pend_off_q <= acc_off;
      end else if (cmpl) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_bypass_ident_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_acc && byp_q) |=> rsp_valid_o && rsp_addr_o == $past(acc_addr_i) && !walk_req_o);

  p_flush_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_i |=> !rsp_valid_o);

  p_probe_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !fill_valid_i) |=> walk_req_o && !rsp_valid_o);

  p_fault_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 3'd0) |-> (rsp_addr_o == '0 && !rsp_used_o));

  p_miss_walk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 3'd1) |-> walk_req_o);

endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bypass_i = 0, boundary_i = 0;
  logic        acc_valid_i = 0, acc_probe_i = 0, acc_sup_i = 0, acc_write_i = 0;
  logic [31:0] acc_addr_i = '0;
  logic        fill_valid_i = 0, fill_err_i = 0;
  logic [19:0] fill_vpn_i = '0, fill_ppn_i = '0;
  logic        fill_glob_i = 0, fill_tag_sup_i = 0, fill_sup_only_i = 0, fill_wprot_i = 0;
  logic        flush_valid_i = 0;
  logic [1:0]  flush_mode_i = '0;
  logic [19:0] flush_vpn_i = '0;
  logic        flush_sup_i = 0;
  logic        rsp_valid_o, rsp_used_o, rsp_mod_o;
  logic [2:0]  rsp_status_o;
  logic [31:0] rsp_addr_o;
  logic        walk_req_o, walk_sup_o, walk_write_o;
  logic [19:0] walk_vpn_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  xlat_cache u0 (.*);

  // {sup, wr, vpn[7:0], status, ppn}
  localparam int NV = 13;
  localparam logic [32:0] TBL [NV] = '{
    {1'b0, 1'b0, 8'h10, 3'd0, 20'hA0010},
    {1'b1, 1'b0, 8'h10, 3'd1, 20'h00000},
    {1'b0, 1'b0, 8'h11, 3'd2, 20'h00000},
    {1'b1, 1'b0, 8'h11, 3'd0, 20'hA0011},
    {1'b0, 1'b1, 8'h12, 3'd3, 20'h00000},
    {1'b1, 1'b0, 8'h12, 3'd0, 20'hA0012},
    {1'b1, 1'b1, 8'h11, 3'd0, 20'hA0011},
    {1'b1, 1'b0, 8'h13, 3'd0, 20'hA0013},
    {1'b0, 1'b0, 8'h13, 3'd1, 20'h00000},
    {1'b0, 1'b1, 8'h14, 3'd2, 20'h00000},
    {1'b1, 1'b1, 8'h14, 3'd3, 20'h00000},
    {1'b0, 1'b0, 8'h20, 3'd1, 20'h00000},
    {1'b0, 1'b0, 8'h12, 3'd0, 20'hA0012}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic access(input logic probe, input logic sup, input logic wr, input logic [31:0] addr);
    @(negedge clk_i);
    acc_valid_i = 1; acc_probe_i = probe; acc_sup_i = sup; acc_write_i = wr; acc_addr_i = addr;
    @(negedge clk_i);
    acc_valid_i = 0;
  endtask

  task automatic look(input string req, input logic sup, input logic wr, input logic [19:0] vpn,
                      input logic [2:0] st, input logic [31:0] exp_addr);
    access(1'b0, sup, wr, {vpn, 12'h345});
    check(req, {31'd0, rsp_valid_o}, 32'd1);
    check(req, {29'd0, rsp_status_o}, {29'd0, st});
    check(req, rsp_addr_o, exp_addr);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic g, input logic tag,
                      input logic so, input logic wp, input logic err);
    @(negedge clk_i);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_glob_i = g; fill_tag_sup_i = tag;
    fill_sup_only_i = so; fill_wprot_i = wp; fill_err_i = err;
    @(negedge clk_i);
    fill_valid_i = 0; fill_err_i = 0;
  endtask

  task automatic flush(input logic [1:0] mode, input logic [19:0] vpn, input logic sup);
    @(negedge clk_i);
    flush_valid_i = 1; flush_mode_i = mode; flush_vpn_i = vpn; flush_sup_i = sup;
    @(negedge clk_i);
    flush_valid_i = 0;
  endtask

  task automatic boundary();
    @(negedge clk_i);
    boundary_i = 1;
    @(negedge clk_i);
    boundary_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  logic [32:0] e;
  string       rq;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // reset state
    check("R8 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    check("R8 reset walk_req", {31'd0, walk_req_o}, 32'd0);
    look("R8 empty miss", 0, 0, 20'h10, 3'd1, 32'h0);
    check("R8 walk pulse", {31'd0, walk_req_o}, 32'd1);
    check("R8 walk vpn", {12'd0, walk_vpn_o}, 32'h10);
    @(negedge clk_i);
    check("R8 walk single cycle", {31'd0, walk_req_o}, 32'd0);

    fill(20'h10, 20'hA0010, 0, 0, 0, 0, 0);
    fill(20'h11, 20'hA0011, 1, 1, 1, 0, 0);
    fill(20'h12, 20'hA0012, 1, 0, 0, 1, 0);
    fill(20'h13, 20'hA0013, 0, 1, 0, 0, 0);
    fill(20'h14, 20'hA0014, 1, 1, 1, 1, 0);

    // R6 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      e = TBL[v];
      rq = (e[22:20] == 3'd0) ? "R6 table" : (e[22:20] == 3'd1) ? "R8 table" : "R7 table";
      look(rq, e[32], e[31], {12'd0, e[30:23]}, e[22:20],
           (e[22:20] == 3'd0) ? {e[19:0], 12'h345} : 32'h0);
      check(rq, {31'd0, walk_req_o}, {31'd0, e[22:20] == 3'd1});
    end

    // R10 history
    look("R10 read", 1, 0, 20'h13, 3'd0, 32'hA0013345);
    check("R10 read mod", {30'd0, rsp_used_o, rsp_mod_o}, 32'd2);
    look("R10 write", 1, 1, 20'h13, 3'd0, 32'hA0013345);
    check("R10 write mod", {30'd0, rsp_used_o, rsp_mod_o}, 32'd3);
    look("R10 persist", 1, 0, 20'h13, 3'd0, 32'hA0013345);
    check("R10 persist mod", {30'd0, rsp_used_o, rsp_mod_o}, 32'd3);

    // R11 priority
    @(negedge clk_i);
    flush_valid_i = 1; flush_mode_i = 2'd2; flush_vpn_i = 20'h40; flush_sup_i = 0;
    acc_valid_i = 1; acc_probe_i = 0; acc_sup_i = 0; acc_write_i = 0; acc_addr_i = 32'h00010345;
    @(negedge clk_i);
    flush_valid_i = 0; acc_valid_i = 0;
    check("R11 flush drops request", {31'd0, rsp_valid_o}, 32'd0);
    @(negedge clk_i);
    fill_valid_i = 1; fill_vpn_i = 20'h15; fill_ppn_i = 20'hB0015; fill_glob_i = 0; fill_tag_sup_i = 1;
    fill_sup_only_i = 0; fill_wprot_i = 0;
    acc_valid_i = 1; acc_addr_i = 32'h00010345;
    @(negedge clk_i);
    fill_valid_i = 0; acc_valid_i = 0;
    check("R11 fill drops request", {31'd0, rsp_valid_o}, 32'd0);
    look("R11 fill taken", 1, 0, 20'h15, 3'd0, 32'hB0015345);
    look("R11 miss-page flush no effect", 0, 0, 20'h10, 3'd0, 32'hA0010345);

    // R5 page flushes
    flush(2'd3, 20'h12, 0);
    look("R5 ng page spares global", 1, 0, 20'h12, 3'd0, 32'hA0012345);
    flush(2'd2, 20'h12, 1);
    look("R5 page needs mode match", 0, 0, 20'h12, 3'd0, 32'hA0012345);
    flush(2'd2, 20'h12, 0);
    look("R5 page flushed", 0, 0, 20'h12, 3'd1, 32'h0);
    flush(2'd3, 20'h13, 1);
    look("R5 ng page flushed", 1, 0, 20'h13, 3'd1, 32'h0);

    // R4 bulk flushes
    flush(2'd1, 20'h0, 0);
    look("R4 nonglobal gone", 0, 0, 20'h10, 3'd1, 32'h0);
    look("R4 global kept", 1, 0, 20'h11, 3'd0, 32'hA0011345);
    look("R4 nonglobal gone b", 1, 0, 20'h15, 3'd1, 32'h0);
    look("R4 global kept b", 1, 1, 20'h14, 3'd3, 32'h0);
    flush(2'd0, 20'h0, 0);
    look("R4 all gone", 1, 0, 20'h11, 3'd1, 32'h0);

    // R1 R2 R3 bypass
    fill(20'h30, 20'hC0030, 0, 0, 0, 0, 0);
    bypass_i = 1;
    repeat (4) @(negedge clk_i);
    look("R2 no boundary keeps translation", 0, 0, 20'h30, 3'd0, 32'hC0030345);
    boundary();
    look("R1 identity", 0, 0, 20'h30, 3'd0, 32'h00030345);
    check("R1 no walk", {31'd0, walk_req_o}, 32'd0);
    access(1'b1, 0, 1, 32'h00077345);
    check("R1 probe identity valid", {31'd0, rsp_valid_o}, 32'd1);
    check("R1 probe identity addr", rsp_addr_o, 32'h00077345);
    check("R1 probe no walk", {31'd0, walk_req_o}, 32'd0);
    flush(2'd0, 20'h0, 0);
    bypass_i = 0;
    repeat (4) @(negedge clk_i);
    look("R2 no boundary keeps bypass", 0, 0, 20'h30, 3'd0, 32'h00030345);
    boundary();
    look("R3 flush during bypass applied", 0, 0, 20'h30, 3'd1, 32'h0);

    // R9 probe
    access(1'b1, 0, 1, 32'h00050345);
    check("R9 probe miss no rsp", {31'd0, rsp_valid_o}, 32'd0);
    check("R9 probe walk", {31'd0, walk_req_o}, 32'd1);
    check("R9 probe walk vpn", {12'd0, walk_vpn_o}, 32'h50);
    access(1'b0, 0, 0, 32'h00030345);
    check("R9 request ignored while pending", {31'd0, rsp_valid_o}, 32'd0);
    check("R9 walk held", {31'd0, walk_req_o}, 32'd1);
    fill(20'h50, 20'hD0050, 0, 0, 0, 0, 0);
    check("R9 fill completes", {31'd0, rsp_valid_o}, 32'd1);
    check("R9 fill status", {29'd0, rsp_status_o}, 32'd0);
    check("R9 fill addr", rsp_addr_o, 32'hD0050345);
    check("R10 fill write sets mod", {31'd0, rsp_mod_o}, 32'd1);
    check("R9 walk dropped", {31'd0, walk_req_o}, 32'd0);
    look("R10 filled entry mod", 0, 0, 20'h50, 3'd0, 32'hD0050345);
    check("R10 filled entry mod bit", {31'd0, rsp_mod_o}, 32'd1);
    access(1'b1, 0, 0, 32'h00051345);
    fill(20'h51, 20'hD0051, 0, 0, 0, 0, 1);
    check("R9 walk error valid", {31'd0, rsp_valid_o}, 32'd1);
    check("R9 walk error status", {29'd0, rsp_status_o}, 32'd4);
    check("R9 walk error addr", rsp_addr_o, 32'h0);
    access(1'b1, 0, 1, 32'h00052345);
    fill(20'h52, 20'hD0052, 0, 0, 0, 1, 0);
    check("R9 fill wprot status", {29'd0, rsp_status_o}, 32'd3);
    look("R9 faulted fill still loaded", 0, 0, 20'h52, 3'd0, 32'hD0052345);

    // R12 round robin and overlap
    flush(2'd0, 20'h0, 0);
    for (int i = 0; i < 16; i++) fill(20'h60 + 20'(i), 20'hF0060 + 20'(i), 0, 0, 0, 0, 0);
    look("R12 first kept", 0, 0, 20'h60, 3'd0, 32'hF0060345);
    look("R12 last kept", 0, 0, 20'h6F, 3'd0, 32'hF006F345);
    fill(20'h70, 20'hF0070, 0, 0, 0, 0, 0);
    look("R12 oldest evicted", 0, 0, 20'h60, 3'd1, 32'h0);
    look("R12 second kept", 0, 0, 20'h61, 3'd0, 32'hF0061345);
    look("R12 new present", 0, 0, 20'h70, 3'd0, 32'hF0070345);
    fill(20'h65, 20'hE0065, 1, 1, 0, 0, 0);
    look("R12 overlap replaced", 0, 0, 20'h65, 3'd0, 32'hE0065345);
    look("R12 next victim", 0, 0, 20'h61, 3'd1, 32'h0);

    summary();
    $finish;
  end

endmodule